// File: doc/BRIEF.md
# Tag-Tracking Floating-Point Register File

This block holds the floating-point architectural registers of an out-of-order core that issues to reservation stations. There are sixteen 64-bit entries. Entry n holds even register F(2n), so entry index = register number / 2. Each entry also carries a 4-bit producer tag. Tag 0 means the stored value is current. A nonzero tag, 1 to 15, names the station that will deliver the entry's next value.

When an instruction issues, its sources are read through two combinational read ports. Each port returns either a ready value with tag 0, or the pending producer tag. At the same time, the rename port stamps the issuing station's ID into the destination entry's tag. Results come back on a common data bus as a value plus the producing station's tag. Every entry whose tag equals that broadcast tag captures the value and becomes ready. A result is therefore written by tag match, not by register address. Because a newer issue replaces the tag, a stale producer's broadcast can never overwrite a newer pending value.

A read that coincides with a matching broadcast forwards the bus value in the same cycle. A rename and a capture that hit the same entry in one cycle resolve in favour of the rename.

Top module: `fprf_tagged`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), every entry is cleared to data 0 and tag 0. After release, every read returns data 0 and tag 0.
- R2: A read of an entry whose tag is 0 returns its stored data with tag 0, combinationally in the same cycle.
- R3: A read of an entry with a nonzero tag and no matching broadcast returns that tag, with the stored (stale) data on the data output.
- R4: With `ren_valid_i` high and `ren_tag_i` nonzero, the entry at `ren_addr_i` takes `ren_tag_i` as its tag at the next clock edge. Its data is unchanged.
- R5: A rename request carrying tag 0 is ignored: no tag or data changes.
- R6: With `cdb_valid_i` high and `cdb_tag_i` nonzero, every entry whose tag equals `cdb_tag_i` loads `cdb_data_i` and clears its tag to 0 at the next edge. Several entries may capture at once.
- R7: A broadcast with `cdb_valid_i` low, or with `cdb_tag_i` equal to 0, changes no entry.
- R8: A second rename of an entry replaces the older tag. A later broadcast of the older tag leaves that entry pending on the newer tag with its data unchanged.
- R9: When a rename and a matching broadcast target the same entry in one cycle, the entry takes the new tag and keeps its old data. The broadcast data is dropped for that entry.
- R10: A read of an entry whose tag matches a valid, nonzero broadcast in the same cycle returns `cdb_data_i` with tag 0.
- R11: A rename is not visible to reads in its own cycle. Reads in that cycle see the entry's state before the rename.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_addr_i | input | 2x4 | Entry index for each read port (F register number / 2) |
| rd_data_o | output | 2x64 | Read data per port (stored, or forwarded from the bus) |
| rd_tag_o | output | 2x4 | Read tag per port; 0 means the data is valid |
| ren_valid_i | input | 1 | Rename request |
| ren_addr_i | input | 4 | Destination entry of the rename |
| ren_tag_i | input | 4 | Issuing station ID (1 to 15) |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | 4 | ID of the station producing the result |
| cdb_data_i | input | 64 | Broadcast result value |

## Verification
Read results are combinational, so they are due in the cycle the address and bus inputs are applied. This includes forwarding from the bus. Rename and capture effects become visible one clock edge later.

The bench works on a fixed schedule. It drives inputs on the falling edge and compares both read ports against its reference model 2 ns later, before the rising edge. It then advances the model only after that rising edge. The same-cycle cases (forwarding, rename hidden from its own cycle) and the next-cycle cases (capture, rename, collisions) are therefore each sampled in their own cycle.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned DefNumRegs = 16;
  localparam int unsigned DefDataW   = 64;
  localparam int unsigned DefTagW    = 4;
  localparam int unsigned DefRdPorts = 2;

  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_RENAME  = 2'd1,
    UPD_CAPTURE = 2'd2
  } upd_e;
endpackage

// File: rtl/fprf_entry.sv
module fprf_entry
  import fprf_pkg::*;
#(
  parameter int unsigned DATA_W = DefDataW,
  parameter int unsigned TAG_W  = DefTagW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_sel_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  tag_q;
  upd_e              upd;

  // rename outranks capture: a newer producer owns the entry
  always_comb begin
    upd = UPD_HOLD;
    if (ren_sel_i) begin
      upd = UPD_RENAME;
    end else if (cdb_valid_i && (cdb_tag_i != '0) && (tag_q == cdb_tag_i)) begin
      upd = UPD_CAPTURE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      unique case (upd)
        UPD_RENAME:  tag_q <= ren_tag_i;
        UPD_CAPTURE: begin
          data_q <= cdb_data_i;
          tag_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  assign data_o = data_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/fprf_ren_dec.sv
module fprf_ren_dec
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DefNumRegs,
  parameter int unsigned TAG_W    = DefTagW,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              ren_valid_i,
  input  logic [ADDR_W-1:0] ren_addr_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  output logic [NUM_REGS-1:0] sel_o
);
  logic ren_ok;
  // a zero station ID would fake a ready entry; drop it
  assign ren_ok = ren_valid_i && (ren_tag_i != '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = ren_ok && (ren_addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/fprf_rd_port.sv
module fprf_rd_port
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DefNumRegs,
  parameter int unsigned DATA_W   = DefDataW,
  parameter int unsigned TAG_W    = DefTagW,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  ent_data_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   ent_tag_i,
  input  logic                             cdb_valid_i,
  input  logic [TAG_W-1:0]                 cdb_tag_i,
  input  logic [DATA_W-1:0]                cdb_data_i,
  output logic [DATA_W-1:0]                data_o,
  output logic [TAG_W-1:0]                 tag_o
);
  logic [DATA_W-1:0] sel_data;
  logic [TAG_W-1:0]  sel_tag;
  logic              fwd;

  assign sel_data = ent_data_i[addr_i];
  assign sel_tag  = ent_tag_i[addr_i];
  // same-cycle result: forward so the issuing op sees it ready
  assign fwd      = cdb_valid_i && (cdb_tag_i != '0) && (sel_tag == cdb_tag_i);

  assign data_o = fwd ? cdb_data_i : sel_data;
  assign tag_o  = fwd ? '0 : sel_tag;
endmodule

// File: rtl/fprf_tagged.sv
module fprf_tagged
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DefNumRegs,
  parameter int unsigned DATA_W   = DefDataW,
  parameter int unsigned TAG_W    = DefTagW,
  parameter int unsigned NUM_RD   = DefRdPorts,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_o,
  output logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag_o,
  input  logic                            ren_valid_i,
  input  logic [ADDR_W-1:0]               ren_addr_i,
  input  logic [TAG_W-1:0]                ren_tag_i,
  input  logic                            cdb_valid_i,
  input  logic [TAG_W-1:0]                cdb_tag_i,
  input  logic [DATA_W-1:0]               cdb_data_i
);
  logic [NUM_REGS-1:0]              ren_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0]  ent_data;
  logic [NUM_REGS-1:0][TAG_W-1:0]   ent_tag;

  fprf_ren_dec #(
    .NUM_REGS(NUM_REGS),
    .TAG_W   (TAG_W)
  ) u_dec (
    .ren_valid_i(ren_valid_i),
    .ren_addr_i (ren_addr_i),
    .ren_tag_i  (ren_tag_i),
    .sel_o      (ren_sel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    fprf_entry #(
      .DATA_W(DATA_W),
      .TAG_W (TAG_W)
    ) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ren_sel_i  (ren_sel[i]),
      .ren_tag_i  (ren_tag_i),
      .cdb_valid_i(cdb_valid_i),
      .cdb_tag_i  (cdb_tag_i),
      .cdb_data_i (cdb_data_i),
      .data_o     (ent_data[i]),
      .tag_o      (ent_tag[i])
    );
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    fprf_rd_port #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W),
      .TAG_W   (TAG_W)
    ) u_rd (
      .addr_i     (rd_addr_i[p]),
      .ent_data_i (ent_data),
      .ent_tag_i  (ent_tag),
      .cdb_valid_i(cdb_valid_i),
      .cdb_tag_i  (cdb_tag_i),
      .cdb_data_i (cdb_data_i),
      .data_o     (rd_data_o[p]),
      .tag_o      (rd_tag_o[p])
    );
  end
endmodule

// File: rtl/fprf_tagged_chk.sv
module fprf_tagged_chk #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag_o,
  input logic                            ren_valid_i,
  input logic [ADDR_W-1:0]               ren_addr_i,
  input logic [TAG_W-1:0]                ren_tag_i,
  input logic                            cdb_valid_i,
  input logic [TAG_W-1:0]                cdb_tag_i,
  input logic [DATA_W-1:0]               cdb_data_i,
  input logic [NUM_REGS-1:0][DATA_W-1:0] ent_data,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag
);
  // R4
  rename_sets_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_tag_i != '0) |=> ent_tag[$past(ren_addr_i)] == $past(ren_tag_i));

  // R5
  zero_rename_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_tag_i == '0 && !cdb_valid_i) |=> $stable(ent_tag));

  // R7
  idle_bus_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cdb_valid_i || cdb_tag_i == '0) |=> $stable(ent_data));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent_chk
    // R6
    capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cdb_valid_i && cdb_tag_i != '0 && ent_tag[i] == cdb_tag_i &&
       !(ren_valid_i && ren_tag_i != '0 && ren_addr_i == ADDR_W'(i)))
      |=> (ent_tag[i] == '0 && ent_data[i] == $past(cdb_data_i)));

    // R9
    rename_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cdb_valid_i && cdb_tag_i != '0 && ent_tag[i] == cdb_tag_i &&
       ren_valid_i && ren_tag_i != '0 && ren_addr_i == ADDR_W'(i))
      |=> ($stable(ent_data[i]) && ent_tag[i] == $past(ren_tag_i)));
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_chk
    // R10
    no_stale_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cdb_valid_i && cdb_tag_i != '0) |-> rd_tag_o[p] != cdb_tag_i);
  end
endmodule

bind fprf_tagged fprf_tagged_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .TAG_W   (TAG_W),
  .NUM_RD  (NUM_RD)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_tag_o   (rd_tag_o),
  .ren_valid_i(ren_valid_i),
  .ren_addr_i (ren_addr_i),
  .ren_tag_i  (ren_tag_i),
  .cdb_valid_i(cdb_valid_i),
  .cdb_tag_i  (cdb_tag_i),
  .cdb_data_i (cdb_data_i),
  .ent_data   (ent_data),
  .ent_tag    (ent_tag)
);

// File: tb/tb_fprf_tagged.sv
module tb_fprf_tagged;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0][3:0]  rd_addr = '0;
  logic [1:0][63:0] rd_data;
  logic [1:0][3:0]  rd_tag;
  logic             ren_v = 1'b0;
  logic [3:0]       ren_a = '0;
  logic [3:0]       ren_t = '0;
  logic             cdb_v = 1'b0;
  logic [3:0]       cdb_t = '0;
  logic [63:0]      cdb_d = '0;

  logic [63:0] m_data [16];
  logic [3:0]  m_tag  [16];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fprf_tagged dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_tag_o(rd_tag),
    .ren_valid_i(ren_v), .ren_addr_i(ren_a), .ren_tag_i(ren_t),
    .cdb_valid_i(cdb_v), .cdb_tag_i(cdb_t), .cdb_data_i(cdb_d)
  );

  task automatic idle();
    ren_v = 1'b0; ren_t = '0; ren_a = '0;
    cdb_v = 1'b0; cdb_t = '0; cdb_d = '0;
  endtask

  // called on a falling edge with inputs set; checks reads, then advances model
  task automatic cyc(input string req);
    #2;
    for (int p = 0; p < 2; p++) begin
      int a = int'(rd_addr[p]);
      logic [63:0] ed = m_data[a];
      logic [3:0]  et = m_tag[a];
      if (et != 0 && cdb_v && cdb_t != 0 && cdb_t == et) begin
        ed = cdb_d; et = '0;
      end
      checks++;
      if (rd_data[p] !== ed || rd_tag[p] !== et) begin
        errors++;
        $display("FAIL %s port %0d entry %0d: data=%h tag=%0d expected data=%h tag=%0d",
                 req, p, a, rd_data[p], rd_tag[p], ed, et);
      end
    end
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      if (ren_v && ren_t != 0 && int'(ren_a) == i) m_tag[i] = ren_t;
      else if (cdb_v && cdb_t != 0 && m_tag[i] == cdb_t) begin
        m_data[i] = cdb_d; m_tag[i] = '0;
      end
    end
    @(negedge clk);
  endtask

  task automatic rd2(input int a0, input int a1);
    rd_addr[0] = 4'(a0); rd_addr[1] = 4'(a1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_data[i] = '0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all entries clean after reset
    for (int a = 0; a < 16; a += 2) begin rd2(a, a + 1); cyc("R1"); end

    // R4 then R3: rename entry 3 to station 5, read it pending
    rd2(0, 1); ren_v = 1; ren_a = 3; ren_t = 5; cyc("R4");
    idle(); rd2(3, 3); cyc("R3");

    // R6: two entries wait on station 7, one broadcast fills both
    ren_v = 1; ren_a = 4; ren_t = 7; cyc("R6");
    ren_a = 9; cyc("R6");
    idle(); cdb_v = 1; cdb_t = 7; cdb_d = 64'h4000_0000_0000_0001; rd2(0, 3); cyc("R6");
    idle(); rd2(4, 9); cyc("R6");
    // R2: ready entries return stored data
    rd2(9, 4); cyc("R2");

    // R10: forwarding in the broadcast cycle
    ren_v = 1; ren_a = 2; ren_t = 11; rd2(4, 5); cyc("R4");
    idle(); cdb_v = 1; cdb_t = 11; cdb_d = 64'h3ff8_0000_0000_0000; rd2(2, 2); cyc("R10");
    idle(); rd2(2, 4); cyc("R2");

    // R11: rename hidden from reads in its own cycle
    ren_v = 1; ren_a = 4; ren_t = 3; rd2(4, 4); cyc("R11");
    idle(); rd2(4, 2); cyc("R3");

    // R7: invalid or zero-tag broadcast changes nothing
    cdb_v = 0; cdb_t = 3; cdb_d = 64'hdead_beef_0000_0003; rd2(4, 0); cyc("R7");
    idle(); cdb_v = 1; cdb_t = 0; cdb_d = 64'hdead_beef_0000_0000; rd2(0, 2); cyc("R7");
    idle(); rd2(0, 2); cyc("R7");
    rd2(4, 9); cyc("R7");

    // R5: zero-tag rename ignored
    ren_v = 1; ren_a = 9; ren_t = 0; rd2(9, 9); cyc("R5");
    idle(); rd2(9, 9); cyc("R5");

    // R8: WAW, older producer cannot overwrite
    ren_v = 1; ren_a = 8; ren_t = 12; rd2(8, 0); cyc("R8");
    ren_t = 13; cyc("R8");
    idle(); cdb_v = 1; cdb_t = 12; cdb_d = 64'h1111_2222_3333_4444; rd2(8, 8); cyc("R8");
    idle(); rd2(8, 8); cyc("R8");
    cdb_v = 1; cdb_t = 13; cdb_d = 64'h5555_6666_7777_8888; cyc("R8");
    idle(); rd2(8, 8); cyc("R8");

    // R9: rename and broadcast collide on one entry
    ren_v = 1; ren_a = 10; ren_t = 14; rd2(10, 10); cyc("R4");
    ren_t = 15; cdb_v = 1; cdb_t = 14; cdb_d = 64'habcd_abcd_abcd_abcd; rd2(0, 1); cyc("R9");
    idle(); rd2(10, 10); cyc("R9");
    cdb_v = 1; cdb_t = 15; cdb_d = 64'h0123_4567_89ab_cdef; rd2(10, 10); cyc("R10");
    idle(); rd2(10, 10); cyc("R9");

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      ren_v = $urandom_range(0, 1) == 1;
      ren_a = 4'($urandom_range(0, 15));
      ren_t = 4'($urandom_range(0, 15));
      cdb_v = $urandom_range(0, 1) == 1;
      cdb_t = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                          : m_tag[$urandom_range(0, 15)];
      cdb_d = {$urandom, $urandom};
      rd2($urandom_range(0, 15), $urandom_range(0, 15));
      cyc("R2");
    end
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule